// File: doc/BRIEF.md
# Base Address Register Bank

This block holds up to six 32-bit base address registers for the configuration space of a device. Each slot's kind is fixed when the design is built. A slot can be empty, an I/O window, a 32-bit memory window, or the lower word of a 64-bit memory window. When a slot is the lower word of a 64-bit window, the slot above it holds the upper 32 address bits. Each window has a power-of-two size and a fixed prefetchable attribute. Address bits below the size boundary are tied to zero. Configuration software can therefore write all ones and read the word back to learn how large the window is.

Software reaches the slots through a dword-addressed register port. The port has a write strobe, write data, and a read path with no register on it. On the other side, the block compares every incoming access address against the programmed windows. It reports every window that matches, and it reports the lowest-numbered match as the selected slot. Two separate enables gate the memory decode and the I/O decode.

Parameters fix each slot's kind, its log2 size and its prefetch flag. Illegal combinations stop elaboration:
- a size that is out of range;
- a 64-bit window in the last slot;
- a slot that is configured above the lower word of a 64-bit window.

Top module: `bar_bank`

## Requirements
- R1: After reset every writable base bit is zero, so each slot reads back only its fixed attribute bits.
- R2: A memory slot's word reads 0 in bit 0. Bits 2:1 read 2'b00 for a 32-bit window and 2'b10 for a 64-bit window. Bit 3 reads the prefetch flag. The base starts at bit 4. Writes to bits 3:0 have no effect.
- R3: An I/O slot's word reads 1 in bit 0 and 0 in bit 1. The base starts at bit 2. Writes to bits 1:0 have no effect.
- R4: Base bits below log2 of the window size always read 0. For example, writing 32'hFFFFFFFF to a 4 KB non-prefetchable 32-bit memory slot reads back 32'hFFFFF000.
- R5: The slot above a 64-bit lower word holds address bits 63:32. It is fully writable for windows of 4 GB or less. For an 8 GB window its bit 0 reads 0, so writing all ones reads back 32'hFFFFFFFE.
- R6: An empty slot reads 32'h0 and ignores writes. Writes to dword indices outside the slot window change no slot.
- R7: Slot k sits at dword index 4+k, which is byte offset 0x10+4k. Reads of any dword index outside 4..4+NSLOT-1 return 32'h0.
- R8: Reads return the current contents in the same cycle without a register. A write takes effect at the rising clock edge where the write strobe is high.
- R9: A memory slot matches when mem_en is high, acc_is_io is low, and acc_addr equals the 64-bit base in every bit at or above the size boundary. For a 32-bit slot this means bits 63:32 must be zero. A base of zero still decodes.
- R10: An I/O slot matches only when io_en and acc_is_io are both high and the address bits at or above the size boundary equal its base, with bits 63:32 zero. A memory access never matches an I/O slot, and an I/O access never matches a memory slot.
- R11: hit_vec flags every matching slot. hit is high when any bit of hit_vec is set. hit_idx gives the lowest-numbered matching slot. Overlapping windows resolve to the lower slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all base bits |
| cfg_word | input | CFG_W | Dword index of the configuration access |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_word, same cycle |
| mem_en | input | 1 | Enables the memory decode |
| io_en | input | 1 | Enables the I/O decode |
| acc_is_io | input | 1 | Access is in I/O space (1) or memory space (0) |
| acc_addr | input | 64 | Access address |
| hit | output | 1 | Some slot matches the access |
| hit_idx | output | IDX_W | Lowest-numbered matching slot |
| hit_vec | output | NSLOT | One bit per slot that matches |

## Verification
Read data and all three decode outputs depend on the inputs alone, with no register in the path. Their results are therefore due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and samples them 1 ns later, with no rising edge in between. A write is due only after the following rising edge. Write checks read the slot at the next falling edge. One check also samples between the strobe and that edge to confirm the old value is still visible. The bench also sweeps every dword index, applies several write patterns to every slot, and runs every address-space and enable combination at each window boundary.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

   typedef enum logic [1:0] {
      SLOT_NONE  = 2'd0,
      SLOT_IO    = 2'd1,
      SLOT_MEM32 = 2'd2,
      SLOT_MEM64 = 2'd3
   } slot_kind_e;

   // dword index of slot 0 (byte offset 0x10)
   localparam int unsigned BAR_WORD0 = 4;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned BASE_W    = 64;
   localparam int unsigned MAX_SLOTS = 6;

   // bits of the 64-bit base that software may set
   function automatic logic [BASE_W-1:0] keep_mask(input int unsigned log2sz,
                                                   input slot_kind_e kind);
      logic [BASE_W-1:0] m;
      m = ~{BASE_W{1'b0}} << log2sz;
      if (kind != SLOT_MEM64) m[BASE_W-1:WORD_W] = '0;
      return m;
   endfunction

   // fixed low nibble of a slot word
   function automatic logic [3:0] attr_bits(input slot_kind_e kind, input bit pref);
      case (kind)
         SLOT_IO:    return 4'b0001;
         SLOT_MEM32: return {pref, 2'b00, 1'b0};
         SLOT_MEM64: return {pref, 2'b10, 1'b0};
         default:    return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/bar_region.sv
module bar_region
   import bar_bank_pkg::*;
#(
   parameter slot_kind_e  KIND   = SLOT_MEM32,
   parameter int unsigned LOG2SZ = 12,
   parameter bit          PREF   = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wdata,
   input  logic [BASE_W-1:0] acc_addr,
   input  logic              kind_en,
   output logic [WORD_W-1:0] word_lo,
   output logic [WORD_W-1:0] word_hi,
   output logic              hit
);

   localparam logic [BASE_W-1:0] WMASK = keep_mask(LOG2SZ, KIND);
   localparam logic [BASE_W-1:0] CMASK = ~{BASE_W{1'b0}} << LOG2SZ;
   localparam logic [3:0]        ATTR  = attr_bits(KIND, PREF);

   generate
      if (KIND == SLOT_NONE) begin : g_bad_kind
         $error("bar_region: an empty slot has no region");
      end
      if (KIND == SLOT_IO && (LOG2SZ < 2 || LOG2SZ > 31)) begin : g_bad_io
         $error("bar_region: I/O size must be 4 bytes to 2 GB");
      end
      if (KIND == SLOT_MEM32 && (LOG2SZ < 4 || LOG2SZ > 31)) begin : g_bad_m32
         $error("bar_region: 32-bit memory size must be 16 bytes to 2 GB");
      end
      if (KIND == SLOT_MEM64 && (LOG2SZ < 4 || LOG2SZ > 63)) begin : g_bad_m64
         $error("bar_region: 64-bit memory size must be 16 bytes to 2^63");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else begin
         if (wr_lo) base_q[WORD_W-1:0]      <= wdata & WMASK[WORD_W-1:0];
         if (wr_hi) base_q[BASE_W-1:WORD_W] <= wdata & WMASK[BASE_W-1:WORD_W];
      end
   end

   assign word_lo = base_q[WORD_W-1:0] | {{(WORD_W-4){1'b0}}, ATTR};
   assign word_hi = base_q[BASE_W-1:WORD_W];

   logic addr_match;
   assign addr_match = ((acc_addr ^ base_q) & CMASK) == '0;
   assign hit        = kind_en & addr_match;

endmodule

// File: rtl/bar_rd_mux.sv
module bar_rd_mux
   import bar_bank_pkg::*;
#(
   parameter int unsigned NSLOT = 6,
   parameter int unsigned CFG_W = 6
)(
   input  logic [CFG_W-1:0]        cfg_word,
   input  logic [NSLOT*WORD_W-1:0] words,
   output logic [WORD_W-1:0]       rdata
);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < int'(NSLOT); i++) begin
         if (cfg_word == CFG_W'(BAR_WORD0 + i)) rdata = words[WORD_W*i +: WORD_W];
      end
   end

endmodule

// File: rtl/bar_hit_pick.sv
module bar_hit_pick #(
   parameter int unsigned NSLOT = 6,
   parameter int unsigned IDX_W = 3
)(
   input  logic [NSLOT-1:0] vec,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = int'(NSLOT) - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
      hit = |vec;
   end

endmodule

// File: rtl/bar_bank.sv
module bar_bank
   import bar_bank_pkg::*;
#(
   parameter int unsigned          NSLOT      = 6,
   parameter int unsigned          CFG_W      = 6,
   parameter logic [2*NSLOT-1:0]   SLOT_KINDS = 12'b10_00_00_11_01_10,
   parameter logic [8*NSLOT-1:0]   SLOT_LOG2  = {8'd4, 8'd0, 8'd0, 8'd33, 8'd5, 8'd12},
   parameter logic [NSLOT-1:0]     SLOT_PREF  = 6'b100100,
   localparam int unsigned         IDX_W      = (NSLOT > 1) ? $clog2(NSLOT) : 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_word,
   input  logic                cfg_we,
   input  logic [WORD_W-1:0]   cfg_wdata,
   output logic [WORD_W-1:0]   cfg_rdata,
   input  logic                mem_en,
   input  logic                io_en,
   input  logic                acc_is_io,
   input  logic [BASE_W-1:0]   acc_addr,
   output logic                hit,
   output logic [IDX_W-1:0]    hit_idx,
   output logic [NSLOT-1:0]    hit_vec
);

   generate
      if (NSLOT < 1 || NSLOT > MAX_SLOTS) begin : g_bad_nslot
         $error("bar_bank: NSLOT must be 1 to 6");
      end
      if ((BAR_WORD0 + NSLOT) > (1 << CFG_W)) begin : g_bad_cfgw
         $error("bar_bank: CFG_W too narrow for the slot window");
      end
   endgenerate

   function automatic slot_kind_e kind_at(input int idx);
      if (idx < 0 || idx >= int'(NSLOT)) return SLOT_NONE;
      return slot_kind_e'(SLOT_KINDS[2*idx +: 2]);
   endfunction

   logic [NSLOT*WORD_W-1:0] slot_words;
   logic [WORD_W-1:0]       hi_word [NSLOT];
   logic [NSLOT-1:0]        sel;

   generate
      for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
         localparam slot_kind_e  KIND = kind_at(s);
         localparam slot_kind_e  PREV = kind_at(s - 1);
         localparam int unsigned LG   = int'(SLOT_LOG2[8*s +: 8]);

         assign sel[s] = (cfg_word == CFG_W'(BAR_WORD0 + s));

         if (PREV == SLOT_MEM64) begin : g_upper
            if (KIND != SLOT_NONE) begin : g_bad_upper
               $error("bar_bank: slot above a 64-bit lower word must be empty");
            end
            assign slot_words[WORD_W*s +: WORD_W] = hi_word[s-1];
            assign hi_word[s] = '0;
            assign hit_vec[s] = 1'b0;
         end else if (KIND == SLOT_NONE) begin : g_empty
            assign slot_words[WORD_W*s +: WORD_W] = '0;
            assign hi_word[s] = '0;
            assign hit_vec[s] = 1'b0;
         end else begin : g_bar
            if (KIND == SLOT_MEM64 && s == int'(NSLOT) - 1) begin : g_bad_last
               $error("bar_bank: a 64-bit window needs a slot above it");
            end

            logic wr_hi;
            logic kind_en;

            if (KIND == SLOT_MEM64) begin : g_hi_wr
               assign wr_hi = cfg_we & (cfg_word == CFG_W'(BAR_WORD0 + s + 1));
            end else begin : g_no_hi
               assign wr_hi = 1'b0;
            end

            if (KIND == SLOT_IO) begin : g_io_space
               assign kind_en = io_en & acc_is_io;
            end else begin : g_mem_space
               assign kind_en = mem_en & ~acc_is_io;
            end

            bar_region #(
               .KIND   (KIND),
               .LOG2SZ (LG),
               .PREF   (SLOT_PREF[s])
            ) u_region (
               .clk      (clk),
               .rst_n    (rst_n),
               .wr_lo    (cfg_we & sel[s]),
               .wr_hi    (wr_hi),
               .wdata    (cfg_wdata),
               .acc_addr (acc_addr),
               .kind_en  (kind_en),
               .word_lo  (slot_words[WORD_W*s +: WORD_W]),
               .word_hi  (hi_word[s]),
               .hit      (hit_vec[s])
            );
         end
      end
   endgenerate

   bar_rd_mux #(
      .NSLOT (NSLOT),
      .CFG_W (CFG_W)
   ) u_rd_mux (
      .cfg_word (cfg_word),
      .words    (slot_words),
      .rdata    (cfg_rdata)
   );

   bar_hit_pick #(
      .NSLOT (NSLOT),
      .IDX_W (IDX_W)
   ) u_pick (
      .vec (hit_vec),
      .hit (hit),
      .idx (hit_idx)
   );

endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk
   import bar_bank_pkg::*;
#(
   parameter int unsigned        NSLOT      = 6,
   parameter int unsigned        CFG_W      = 6,
   parameter logic [2*NSLOT-1:0] SLOT_KINDS = '0,
   parameter logic [8*NSLOT-1:0] SLOT_LOG2  = '0,
   parameter logic [NSLOT-1:0]   SLOT_PREF  = '0,
   parameter int unsigned        IDX_W      = 3
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic [CFG_W-1:0]        cfg_word,
   input logic                    cfg_we,
   input logic [WORD_W-1:0]       cfg_rdata,
   input logic                    mem_en,
   input logic                    io_en,
   input logic                    acc_is_io,
   input logic                    hit,
   input logic [IDX_W-1:0]        hit_idx,
   input logic [NSLOT-1:0]        hit_vec,
   input logic [NSLOT*WORD_W-1:0] slot_words
);

   function automatic slot_kind_e kind_of(input int idx);
      if (idx < 0 || idx >= int'(NSLOT)) return SLOT_NONE;
      return slot_kind_e'(SLOT_KINDS[2*idx +: 2]);
   endfunction

   function automatic logic [WORD_W-1:0] zero_mask(input int lg, input slot_kind_e k, input bit upper);
      if (upper) return (lg > 32) ? ((WORD_W'(1) << (lg - 32)) - WORD_W'(1)) : '0;
      if (k == SLOT_IO) return ((WORD_W'(1) << lg) - WORD_W'(1)) & ~WORD_W'(3);
      return ((WORD_W'(1) << lg) - WORD_W'(1)) & ~WORD_W'(15);
   endfunction

   // R7: reads outside the slot window return zero
   p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_word) < int'(BAR_WORD0) || int'(cfg_word) >= int'(BAR_WORD0 + NSLOT))
         |-> cfg_rdata == '0);

   // R8: without a write strobe no slot changes at the next edge
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(slot_words));

   // R11: selected index is a set bit and the lowest one
   p_pick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_vec[hit_idx] &&
               ((hit_vec & ((NSLOT'(1) << hit_idx) - NSLOT'(1))) == '0)));

   p_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> hit_vec == '0);

   generate
      for (genvar s = 0; s < int'(NSLOT); s++) begin : g_chk
         localparam slot_kind_e KIND = kind_of(s);
         localparam bit         UP   = (kind_of(s - 1) == SLOT_MEM64);
         localparam int         LG   = UP ? int'(SLOT_LOG2[8*(s-1) +: 8]) : int'(SLOT_LOG2[8*s +: 8]);
         localparam logic [WORD_W-1:0] ZM = zero_mask(LG, KIND, UP);

         if (UP) begin : g_up
            // R5: upper word keeps bits below the boundary clear
            p_upper_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (slot_words[WORD_W*s +: WORD_W] & ZM) == '0);
         end else if (KIND == SLOT_NONE) begin : g_none
            // R6: empty slot always reads zero
            p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
               slot_words[WORD_W*s +: WORD_W] == '0);
         end else if (KIND == SLOT_IO) begin : g_io
            // R3: fixed I/O attribute bits
            p_io_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
               slot_words[WORD_W*s +: 2] == 2'b01);
            // R4: bits below the size boundary read zero
            p_io_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
               (slot_words[WORD_W*s +: WORD_W] & ZM) == '0);
            // R10: I/O slot matches only I/O accesses with io_en
            p_io_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
               hit_vec[s] |-> (acc_is_io && io_en));
         end else begin : g_mem
            // R2: fixed memory attribute nibble
            p_mem_attr_r2: assert property (@(posedge clk) disable iff (!rst_n)
               slot_words[WORD_W*s +: 4] ==
                  {SLOT_PREF[s], (KIND == SLOT_MEM64) ? 2'b10 : 2'b00, 1'b0});
            // R4: bits below the size boundary read zero
            p_mem_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
               (slot_words[WORD_W*s +: WORD_W] & ZM) == '0);
            // R9: memory slot matches only memory accesses with mem_en
            p_mem_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
               hit_vec[s] |-> (!acc_is_io && mem_en));
         end
      end
   endgenerate

endmodule

bind bar_bank bar_bank_chk #(
   .NSLOT      (NSLOT),
   .CFG_W      (CFG_W),
   .SLOT_KINDS (SLOT_KINDS),
   .SLOT_LOG2  (SLOT_LOG2),
   .SLOT_PREF  (SLOT_PREF),
   .IDX_W      (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_word   (cfg_word),
   .cfg_we     (cfg_we),
   .cfg_rdata  (cfg_rdata),
   .mem_en     (mem_en),
   .io_en      (io_en),
   .acc_is_io  (acc_is_io),
   .hit        (hit),
   .hit_idx    (hit_idx),
   .hit_vec    (hit_vec),
   .slot_words (slot_words)
);

// File: tb/sim_bar_bank.sv
`timescale 1ns/1ps
module sim_bar_bank;

   // bench view of the default configuration: 0 empty, 1 io, 2 mem32, 3 mem64
   localparam int K  [6] = '{2, 1, 3, 0, 0, 2};
   localparam int LG [6] = '{12, 5, 33, 0, 0, 4};
   localparam int PF [6] = '{0, 0, 1, 0, 0, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_word = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_en = 1'b0;
   logic        io_en = 1'b0;
   logic        acc_is_io = 1'b0;
   logic [63:0] acc_addr = '0;
   logic        hit;
   logic [2:0]  hit_idx;
   logic [5:0]  hit_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [63:0] mdl [6];

   always #2 clk = ~clk;

   bar_bank u0 (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en),
      .io_en(io_en), .acc_is_io(acc_is_io), .acc_addr(acc_addr),
      .hit(hit), .hit_idx(hit_idx), .hit_vec(hit_vec)
   );

   function automatic logic [63:0] wmask(input int r);
      logic [63:0] m;
      m = ~64'd0 << LG[r];
      if (K[r] != 3) m[63:32] = '0;
      return m;
   endfunction

   function automatic logic [31:0] attr(input int r);
      case (K[r])
         1: return 32'h1;
         2: return PF[r] ? 32'h8 : 32'h0;
         3: return PF[r] ? 32'hC : 32'h4;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_word(input int s);
      if (K[s] != 0) return mdl[s][31:0] | attr(s);
      if (s > 0 && K[s-1] == 3) return mdl[s-1][63:32];
      return 32'h0;
   endfunction

   function automatic string tag_of(input int s);
      if (K[s] == 1) return "R3";
      if (K[s] != 0) return "R2 R4";
      if (s > 0 && K[s-1] == 3) return "R5";
      return "R6";
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic model_write(input int a, input logic [31:0] d);
      int s;
      s = a - 4;
      if (s < 0 || s > 5) return;
      if (K[s] != 0) mdl[s][31:0] = d & wmask(s)[31:0];
      else if (s > 0 && K[s-1] == 3) mdl[s-1][63:32] = d & wmask(s-1)[63:32];
   endtask

   task automatic cfg_write(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_word = 6'(a); cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic read_slot(input int s, input string req);
      cfg_word = 6'(4 + s);
      #1;
      chk(req, {32'h0, cfg_rdata}, {32'h0, exp_word(s)});
   endtask

   task automatic sweep_words(input string req);
      for (int a = 0; a < 64; a++) begin
         cfg_word = 6'(a);
         #1;
         if (a >= 4 && a < 10) chk(req, {32'h0, cfg_rdata}, {32'h0, exp_word(a - 4)});
         else chk(req, {32'h0, cfg_rdata}, 64'h0);
      end
   endtask

   task automatic probe(input logic [63:0] a);
      for (int c = 0; c < 8; c++) begin
         logic [5:0] ev;
         int lo;
         acc_addr = a; acc_is_io = c[0]; mem_en = c[1]; io_en = c[2];
         #1;
         ev = '0; lo = 0;
         for (int r = 5; r >= 0; r--) begin
            logic m;
            m = (((a ^ mdl[r]) & (~64'd0 << LG[r])) == 64'd0);
            if (K[r] == 1)      ev[r] = io_en && acc_is_io && m;
            else if (K[r] != 0) ev[r] = mem_en && !acc_is_io && m;
            if (ev[r]) lo = r;
         end
         chk("R9 R10 hit_vec", {58'h0, hit_vec}, {58'h0, ev});
         chk("R11 hit", {63'h0, hit}, {63'h0, |ev});
         if (|ev) chk("R11 hit_idx", {61'h0, hit_idx}, 64'(lo));
      end
   endtask

   task automatic probe_all();
      for (int r = 0; r < 6; r++) begin
         if (K[r] != 0) begin
            logic [63:0] b, sz;
            b = mdl[r]; sz = 64'd1 << LG[r];
            probe(b); probe(b + sz - 1); probe(b + sz); probe(b - 1);
            probe(b ^ (64'd1 << 63)); probe(b ^ (64'd1 << 32));
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] pats [8];
      pats = '{32'hFFFFFFFF, 32'h00000000, 32'hA5A5A5A5, 32'h5A5A5A5A,
               32'h12345678, 32'hDEADBEEF, 32'h80000001, 32'h0F0F0F0F};
      for (int r = 0; r < 6; r++) mdl[r] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values, literal
      cfg_word = 6'd4; #1; chk("R1 slot0", {32'h0, cfg_rdata}, 64'h0);
      cfg_word = 6'd5; #1; chk("R1 slot1", {32'h0, cfg_rdata}, 64'h1);
      cfg_word = 6'd6; #1; chk("R1 slot2", {32'h0, cfg_rdata}, 64'hC);
      cfg_word = 6'd7; #1; chk("R1 slot3", {32'h0, cfg_rdata}, 64'h0);
      cfg_word = 6'd8; #1; chk("R1 slot4", {32'h0, cfg_rdata}, 64'h0);
      cfg_word = 6'd9; #1; chk("R1 slot5", {32'h0, cfg_rdata}, 64'h8);
      sweep_words("R7 reset sweep");

      // R11/R9: zero bases decode once enabled
      probe(64'h0000_0000_0000_0ABC);
      probe_all();

      // R4 R2 R3 R5: size probing with all ones
      for (int s = 0; s < 6; s++) cfg_write(4 + s, 32'hFFFFFFFF);
      cfg_word = 6'd4; #1; chk("R4 slot0 size", {32'h0, cfg_rdata}, 64'hFFFFF000);
      cfg_word = 6'd5; #1; chk("R3 slot1 size", {32'h0, cfg_rdata}, 64'hFFFFFFE1);
      cfg_word = 6'd6; #1; chk("R2 slot2 low", {32'h0, cfg_rdata}, 64'h0000000C);
      cfg_word = 6'd7; #1; chk("R5 slot3 high", {32'h0, cfg_rdata}, 64'hFFFFFFFE);
      cfg_word = 6'd8; #1; chk("R6 slot4 empty", {32'h0, cfg_rdata}, 64'h0);
      cfg_word = 6'd9; #1; chk("R2 slot5 size", {32'h0, cfg_rdata}, 64'hFFFFFFF8);

      // pattern sweep over every slot
      for (int p = 0; p < 8; p++) begin
         for (int s = 0; s < 6; s++) begin
            cfg_write(4 + s, pats[p]);
            read_slot(s, tag_of(s));
         end
         sweep_words("R7 sweep");
      end

      // R6: writes outside the window change nothing
      cfg_write(0, 32'hFFFFFFFF);
      cfg_write(3, 32'hFFFFFFFF);
      cfg_write(10, 32'hFFFFFFFF);
      cfg_write(63, 32'hFFFFFFFF);
      sweep_words("R6 outside writes");

      // R8: write visible only after the edge
      cfg_write(4, 32'h0000_0000);
      @(negedge clk);
      cfg_word = 6'd4; cfg_we = 1'b1; cfg_wdata = 32'hABCD_E000;
      #1; chk("R8 before edge", {32'h0, cfg_rdata}, 64'h0);
      @(negedge clk);
      cfg_we = 1'b0;
      #1; chk("R8 after edge", {32'h0, cfg_rdata}, 64'hABCDE000);
      model_write(4, 32'hABCD_E000);

      // program windows for decode
      cfg_write(4, 32'h1234_5000);
      cfg_write(5, 32'h0000_0C40);
      cfg_write(6, 32'h0000_0000);
      cfg_write(7, 32'h0000_0006);
      cfg_write(9, 32'h1234_5010);

      acc_addr = 64'h0000_0000_1234_5010; acc_is_io = 1'b0; mem_en = 1'b1; io_en = 1'b1;
      #1;
      chk("R11 overlap vec", {58'h0, hit_vec}, 64'h21);
      chk("R11 overlap idx", {61'h0, hit_idx}, 64'h0);
      acc_addr = 64'h0000_0006_0000_1234;
      #1; chk("R9 mem64 vec", {58'h0, hit_vec}, 64'h04);
      acc_addr = 64'h0000_0004_0000_0000;
      #1; chk("R9 mem64 miss", {58'h0, hit_vec}, 64'h00);
      acc_addr = 64'h0000_0000_0000_0C5F; acc_is_io = 1'b1;
      #1; chk("R10 io vec", {58'h0, hit_vec}, 64'h02);
      acc_is_io = 1'b0;
      #1; chk("R10 mem miss io", {58'h0, hit_vec}, 64'h00);

      probe_all();
      probe(64'h0000_0000_1234_5010);
      probe(64'h0000_0001_1234_5010);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule